// File: doc/BRIEF.md
# Four-Phase 16-bit Load/Store Processor Core

This block is a compact 16-bit processor with sixteen 16-bit general registers and three-operand instructions. Register 15 doubles as the program counter. No separate incrementer advances it: the single adder that serves user arithmetic also adds the step of 2 to the PC, in a different phase of the same instruction. Every instruction runs through a fixed four-cycle rotation. The PC update and the user operation alternate, so each result has reached the register file before the next instruction reads its operands, and the datapath has no forwarding paths.

The core connects to an instruction fetch port, which returns the word at the presented address in the same cycle, and to one data memory port. A request on the data port is held until the memory accepts it, and the phase rotation freezes for that whole time. A synchronous active-low reset clears the machine state. The instruction set covers add, subtract, four bitwise operations, load-immediate, load, store and an unconditional relative branch.

Top module: `quad16_core`

## Requirements
- R1: While reset is asserted and after its release, every register (including r15) holds zero, the rotation starts in its first phase, `imem_addr` is 0 and `dmem_valid` is low.
- R2: An instruction that does not touch data memory takes exactly four clock cycles. `imem_addr` moves to the next instruction (old value + 2) on the fourth rising edge of that instruction.
- R3: A word with bit 15 = 0 is a register instruction: bits 14:12 opcode, 11:8 rd, 7:4 ra, 3:0 rb. The opcodes are 0 add, 1 subtract (ra − rb), 2 AND, 3 OR, 4 XOR and 5 XNOR, each writing rd modulo 2^16.
- R4: Register opcodes 6 and 7, memory-format (bits 15:14 = 10) operations 2 and 3, and immediate-format (bits 15:14 = 11) operations 2 and 3 change no register.
- R5: Immediate-format operation 0 (bits 13:12 = 00) loads bits 7:0, zero-extended, into rd (bits 11:8).
- R6: An instruction may read a register written by the instruction directly before it and gets the new value, with no extra cycles.
- R7: Memory-format operation 1 (bits 13:12 = 01) is a store. It drives `dmem_addr` = ra + zero-extended bits 3:0, `dmem_wdata` = rd and `dmem_we` = 1.
- R8: Memory-format operation 0 is a load. It places `dmem_rdata` at the accepting edge into rd, at the same effective address as a store.
- R9: A data request is raised only in the third phase. While `dmem_ready` is low, the rotation holds and the address, write data and direction stay stable. A memory instruction therefore lasts 4 + (stalled cycles) cycles.
- R10: Immediate-format operation 1 (bits 13:12 = 01) is a branch. The next PC is the branch's own address + 2 + 2 × sign-extended bits 7:0, so an offset of −1 (0xFF) branches to itself.
- R11: A result or load whose rd is 15 is discarded, so the PC is changed only by sequencing and branches. Reading r15 as an operand yields the address of the instruction that reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 16 | Byte address of the instruction being fetched (r15) |
| imem_data | input | 16 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_valid | output | 1 | Data request pending |
| dmem_we | output | 1 | 1 = store, 0 = load, meaningful while `dmem_valid` |
| dmem_addr | output | 16 | Effective data address |
| dmem_wdata | output | 16 | Store data |
| dmem_ready | input | 1 | Memory accepts the request at this rising edge |
| dmem_rdata | input | 16 | Load data, sampled with `dmem_ready` |

## Verification
The bench builds the core with its default parameters: 16-bit data, sixteen registers and a PC step of 2. It drives the data port with zero, two and three wait states. Zero wait states exercise the plain four-cycle rotation and back-to-back register dependencies. The longer waits bring within reach the freeze of the rotation, the stability of a held request and the exact instruction length of 4 + waits. Programs that reach the edges of the field encodings bring several further cases within reach: results that wrap or set the top bit, an immediate with its top bit set, the largest 4-bit address offset, a forward branch, a branch to itself and a write that targets r15.

// File: rtl/quad16_pkg.sv
// quad16_pkg
// Shared encodings of the four-phase core: instruction opcodes and the
// logic-unit operation select. Assumes the fixed 16-bit instruction layout.
package quad16_pkg;

    // register-format opcodes (bits 14:12)
    localparam logic [2:0] ROP_ADD  = 3'd0;
    localparam logic [2:0] ROP_SUB  = 3'd1;
    localparam logic [2:0] ROP_AND  = 3'd2;
    localparam logic [2:0] ROP_OR   = 3'd3;
    localparam logic [2:0] ROP_XOR  = 3'd4;
    localparam logic [2:0] ROP_XNOR = 3'd5;

    // memory-format operations (bits 13:12)
    localparam logic [1:0] MOP_LOAD  = 2'd0;
    localparam logic [1:0] MOP_STORE = 2'd1;

    // immediate-format operations (bits 13:12)
    localparam logic [1:0] IOP_LDI = 2'd0;
    localparam logic [1:0] IOP_BR  = 2'd1;

    typedef enum logic [1:0] {
        LOP_AND,
        LOP_OR,
        LOP_XOR,
        LOP_XNOR
    } lop_e;

endpackage

// File: rtl/quad16_phase.sv
// quad16_phase
// One-hot phase rotation of the core. Bit 0 is the first phase. The
// rotation advances every cycle unless hold_i is high.
// Assumes hold_i is raised only while a memory request waits.
module quad16_phase #(
    parameter int NPHASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    output logic [NPHASE-1:0] phase_o
);

    logic [NPHASE-1:0] phase_q;

    // rotate the one-hot phase, or keep it while frozen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= NPHASE'(1);
        end else if (!hold_i) begin
            phase_q <= {phase_q[NPHASE-2:0], phase_q[NPHASE-1]};
        end
    end

    assign phase_o = phase_q;

    p_phase_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_q) == 1)
        else $error("phase vector not one-hot");

    p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(phase_q))
        else $error("phase moved during a memory stall");

endmodule

// File: rtl/quad16_regfile.sv
// quad16_regfile
// General register file: two combinational read ports and one write port.
// All registers clear on reset. The caller arbitrates the single write
// port between result write-back and PC write-back by phase.
module quad16_regfile #(
    parameter int XLEN = 16,
    parameter int NREG = 16,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  raddr_a,
    output logic [XLEN-1:0] rdata_a,
    input  logic [RAW-1:0]  raddr_b,
    output logic [XLEN-1:0] rdata_b,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata
);

    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // hold one register; load it when addressed by the write port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && waddr == RAW'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/quad16_alu.sv
// quad16_alu
// Shared adder (with carry-in, so that subtract uses an inverted operand)
// and the four-function logic unit. Purely combinational.
module quad16_alu
    import quad16_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            cin,
    input  lop_e            lop,
    output logic [XLEN-1:0] sum,
    output logic [XLEN-1:0] lout
);

    // adder shared by PC stepping, arithmetic, addresses and branches
    assign sum = a + b + XLEN'(cin);

    // bitwise unit
    always_comb begin
        unique case (lop)
            LOP_AND:  lout = a & b;
            LOP_OR:   lout = a | b;
            LOP_XOR:  lout = a ^ b;
            default:  lout = ~(a ^ b);
        endcase
    end

endmodule

// File: rtl/quad16_core.sv
// quad16_core
// Four-phase 16-bit load/store core with r15 as program counter.
//   phase 1: write back previous result, latch instruction, adder: PC + step
//   phase 2: read operand registers
//   phase 3: write back PC (or branch target), run user op / memory access
//   phase 4: read PC for the next fetch
// Assumes imem_data answers imem_addr combinationally. The data memory
// holds the core in phase 3 until dmem_ready.
module quad16_core
    import quad16_pkg::*;
#(
    parameter int XLEN    = 16,
    parameter int NREG    = 16,
    parameter int ILEN    = 16,
    parameter int PC_STEP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_data,
    output logic            dmem_valid,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic            dmem_ready,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int NPHASE = 4;
    localparam int RAW    = $clog2(NREG);
    localparam logic [RAW-1:0] PC_REG = RAW'(NREG - 1);

    logic [NPHASE-1:0] phase;
    logic              stall, adv3;
    logic [ILEN-1:0]   ir_q;
    logic [XLEN-1:0]   pc_q, pc_inc_q, opa_q, opb_q, res_q;
    logic              wb_en_q;
    logic [RAW-1:0]    wb_rd_q;

    // decoded fields of the latched instruction
    logic [2:0]      rop;
    logic [1:0]      sop;
    logic [RAW-1:0]  f_rd, f_ra, f_rb;
    logic            is_reg, is_ls, is_imm, is_load, is_store, is_ldi, is_br, is_alu, memop;
    logic [XLEN-1:0] imm4_z, imm8_z, br_off;

    assign rop      = ir_q[14:12];
    assign sop      = ir_q[13:12];
    assign f_rd     = ir_q[11:8];
    assign f_ra     = ir_q[7:4];
    assign f_rb     = ir_q[3:0];
    assign is_reg   = ~ir_q[15];
    assign is_ls    = ir_q[15:14] == 2'b10;
    assign is_imm   = ir_q[15:14] == 2'b11;
    assign is_load  = is_ls && sop == MOP_LOAD;
    assign is_store = is_ls && sop == MOP_STORE;
    assign is_ldi   = is_imm && sop == IOP_LDI;
    assign is_br    = is_imm && sop == IOP_BR;
    assign is_alu   = is_reg && rop <= ROP_XNOR;
    assign memop    = is_load | is_store;
    assign imm4_z   = {{(XLEN-4){1'b0}}, ir_q[3:0]};
    assign imm8_z   = {{(XLEN-8){1'b0}}, ir_q[7:0]};
    assign br_off   = {{(XLEN-9){ir_q[7]}}, ir_q[7:0], 1'b0};

    assign stall = phase[2] && memop && !dmem_ready;
    assign adv3  = phase[2] && !stall;

    quad16_phase #(.NPHASE(NPHASE)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (stall),
        .phase_o(phase)
    );

    // register file ports
    logic [RAW-1:0]  rf_ra, rf_rb, rf_waddr;
    logic [XLEN-1:0] rf_da, rf_db, rf_wdata;
    logic            rf_we;

    // adder and logic unit ports
    logic [XLEN-1:0] add_a, add_b, sum, lout;
    logic            add_cin;
    lop_e            lop;

    assign rf_ra = phase[3] ? PC_REG : f_ra;
    assign rf_rb = is_store ? f_rd : f_rb;

    quad16_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .raddr_a(rf_ra),
        .rdata_a(rf_da),
        .raddr_b(rf_rb),
        .rdata_b(rf_db),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata)
    );

    // share the single write port: results in phase 1, PC in phase 3
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = wb_rd_q;
        rf_wdata = res_q;
        if (phase[0]) begin
            rf_we = wb_en_q && (wb_rd_q != PC_REG);
        end else if (adv3) begin
            rf_we    = 1'b1;
            rf_waddr = PC_REG;
            rf_wdata = is_br ? sum : pc_inc_q;
        end
    end

    // steer the shared adder by phase and instruction kind
    always_comb begin
        add_a   = opa_q;
        add_b   = opb_q;
        add_cin = 1'b0;
        if (phase[0]) begin
            add_a = pc_q;
            add_b = XLEN'(PC_STEP);
        end else if (is_ls) begin
            add_b = imm4_z;
        end else if (is_br) begin
            add_a = pc_inc_q;
            add_b = br_off;
        end else if (is_reg && rop == ROP_SUB) begin
            add_b   = ~opb_q;
            add_cin = 1'b1;
        end
    end

    // map register opcodes to logic-unit functions
    always_comb begin
        unique case (rop)
            ROP_AND: lop = LOP_AND;
            ROP_OR:  lop = LOP_OR;
            ROP_XOR: lop = LOP_XOR;
            default: lop = LOP_XNOR;
        endcase
    end

    quad16_alu #(.XLEN(XLEN)) u_alu (
        .a   (add_a),
        .b   (add_b),
        .cin (add_cin),
        .lop (lop),
        .sum (sum),
        .lout(lout)
    );

    // phase-ordered pipeline registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q     <= '0;
            pc_q     <= '0;
            pc_inc_q <= '0;
            opa_q    <= '0;
            opb_q    <= '0;
            res_q    <= '0;
            wb_en_q  <= 1'b0;
            wb_rd_q  <= '0;
        end else begin
            if (phase[0]) begin
                ir_q     <= imem_data;
                pc_inc_q <= sum;
            end
            if (phase[1]) begin
                opa_q <= rf_da;
                opb_q <= rf_db;
            end
            if (adv3) begin
                wb_en_q <= is_alu | is_ldi | is_load;
                wb_rd_q <= f_rd;
                if (is_load)                            res_q <= dmem_rdata;
                else if (is_ldi)                        res_q <= imm8_z;
                else if (rop == ROP_ADD || rop == ROP_SUB) res_q <= sum;
                else                                    res_q <= lout;
            end
            if (phase[3]) begin
                pc_q <= rf_da;
            end
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_valid = phase[2] && memop;
    assign dmem_we    = phase[2] && is_store;
    assign dmem_addr  = sum;
    assign dmem_wdata = opb_q;

    p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_valid && !dmem_ready) |=> (dmem_valid && $stable(dmem_addr)
                                        && $stable(dmem_wdata) && $stable(dmem_we)))
        else $error("data request changed while waiting");

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && !is_br) |=> pc_q == $past(pc_q) + XLEN'(PC_STEP))
        else $error("sequential PC did not advance by the step");

    p_br_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && is_br) |=> pc_q == $past(pc_q) + XLEN'(PC_STEP) + br_off)
        else $error("branch target wrong");

    p_pc_write_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == PC_REG) |-> phase[2])
        else $error("r15 written outside the PC write-back phase");

endmodule

// File: tb/quad16_core_bench.sv
module quad16_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, imem_data;
    logic        dmem_valid, dmem_we, dmem_ready;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;

    logic [15:0] prog [64];
    logic [15:0] dm   [64];
    logic [15:0] st_addr [32];
    logic [15:0] st_data [32];
    int          st_cnt = 0;
    int          lat = 0;
    int          wcnt = 0;
    int          checks = 0;
    int          errors = 0;

    localparam logic [15:0] HALT = 16'hD0FF;   // branch to itself
    localparam logic [15:0] FILL = 16'h6000;   // register opcode 6

    always #10 clk = ~clk;

    assign imem_data = prog[imem_addr[6:1]];

    quad16_core u_quad16_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .dmem_valid(dmem_valid),
        .dmem_we   (dmem_we),
        .dmem_addr (dmem_addr),
        .dmem_wdata(dmem_wdata),
        .dmem_ready(dmem_ready),
        .dmem_rdata(dmem_rdata)
    );

    function automatic logic [15:0] enc_r(input logic [2:0] op, input logic [3:0] rd, ra, rb);
        return {1'b0, op, rd, ra, rb};
    endfunction
    function automatic logic [15:0] enc_m(input logic [1:0] op, input logic [3:0] rd, ra, imm);
        return {2'b10, op, rd, ra, imm};
    endfunction
    function automatic logic [15:0] enc_i(input logic [1:0] op, input logic [3:0] rd, input logic [7:0] imm);
        return {2'b11, op, rd, imm};
    endfunction

    // data memory model with a programmable number of wait cycles
    initial begin
        dmem_ready = 1'b0;
        dmem_rdata = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                dmem_ready = 1'b0;
                wcnt = 0;
            end else if (dmem_ready) begin
                dmem_ready = 1'b0;
            end else if (dmem_valid) begin
                if (wcnt == lat) begin
                    wcnt = 0;
                    dmem_ready = 1'b1;
                    if (dmem_we) begin
                        dm[dmem_addr[5:0]] = dmem_wdata;
                        if (st_cnt < 32) begin
                            st_addr[st_cnt] = dmem_addr;
                            st_data[st_cnt] = dmem_wdata;
                        end
                        st_cnt++;
                    end else begin
                        dmem_rdata = dm[dmem_addr[5:0]];
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_store(input string tag, input int idx, input logic [15:0] a, input logic [15:0] d);
        chk({tag, " store addr"}, st_addr[idx], a);
        chk({tag, " store data"}, st_data[idx], d);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = FILL;
    endtask

    // reset the core with a given memory latency; returns at a falling edge
    task automatic start(input int lat_v);
        lat = lat_v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        st_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset state, registers read as zero
    task automatic t_reset();
        clear_prog();
        prog[0] = enc_m(2'd1, 4'd5, 4'd0, 4'd3);
        prog[1] = HALT;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 imem_addr in reset", imem_addr, 16'h0000);
        chk("R1 dmem_valid in reset", {15'd0, dmem_valid}, 16'h0000);
        st_cnt = 0;
        rst_n = 1'b1;
        step(1);
        chk("R1 imem_addr after release", imem_addr, 16'h0000);
        step(30);
        chk("R1 store count", 16'(st_cnt), 16'd1);
        chk_store("R1 r5 cleared", 0, 16'h0003, 16'h0000);
    endtask

    // R2: four cycles per instruction, address step of 2
    task automatic t_timing();
        clear_prog();
        start(0);
        step(3);
        chk("R2 addr after 3 edges", imem_addr, 16'h0000);
        step(1);
        chk("R2 addr after 4 edges", imem_addr, 16'h0002);
        step(3);
        chk("R2 addr after 7 edges", imem_addr, 16'h0002);
        step(1);
        chk("R2 addr after 8 edges", imem_addr, 16'h0004);
        step(4);
        chk("R2 addr after 12 edges", imem_addr, 16'h0006);
    endtask

    // R3 R5 R6: register ops with back-to-back dependencies
    task automatic t_alu();
        clear_prog();
        prog[0] = enc_i(2'd0, 4'd1, 8'h35);
        prog[1] = enc_i(2'd0, 4'd2, 8'hCA);
        prog[2] = enc_r(3'd0, 4'd3, 4'd1, 4'd2);
        prog[3] = enc_r(3'd1, 4'd4, 4'd1, 4'd2);
        prog[4] = enc_r(3'd2, 4'd5, 4'd4, 4'd3);
        prog[5] = enc_r(3'd3, 4'd6, 4'd4, 4'd2);
        prog[6] = enc_r(3'd4, 4'd7, 4'd4, 4'd1);
        prog[7] = enc_r(3'd5, 4'd8, 4'd4, 4'd3);
        for (int k = 1; k <= 8; k++) prog[7+k] = enc_m(2'd1, 4'(k), 4'd0, 4'(k));
        prog[16] = HALT;
        start(0);
        step(100);
        chk("R3 store count", 16'(st_cnt), 16'd8);
        chk_store("R5 ldi small", 0, 16'd1, 16'h0035);
        chk_store("R5 ldi zero-extend", 1, 16'd2, 16'h00CA);
        chk_store("R3 add", 2, 16'd3, 16'h00FF);
        chk_store("R3 sub wrap R6", 3, 16'd4, 16'hFF6B);
        chk_store("R3 and R6", 4, 16'd5, 16'h006B);
        chk_store("R3 or", 5, 16'd6, 16'hFFEB);
        chk_store("R3 xor", 6, 16'd7, 16'hFF5E);
        chk_store("R3 xnor", 7, 16'd8, 16'h006B);
    endtask

    // R4: unassigned operations leave registers alone
    task automatic t_nop();
        clear_prog();
        prog[0] = enc_i(2'd0, 4'd1, 8'h11);
        prog[1] = enc_r(3'd7, 4'd1, 4'd1, 4'd1);
        prog[2] = enc_r(3'd6, 4'd1, 4'd1, 4'd1);
        prog[3] = enc_m(2'd2, 4'd1, 4'd1, 4'd1);
        prog[4] = enc_m(2'd3, 4'd1, 4'd1, 4'd1);
        prog[5] = enc_i(2'd2, 4'd1, 8'hFF);
        prog[6] = enc_i(2'd3, 4'd1, 8'hFF);
        prog[7] = enc_m(2'd1, 4'd1, 4'd0, 4'd0);
        prog[8] = HALT;
        start(0);
        step(60);
        chk("R4 store count", 16'(st_cnt), 16'd1);
        chk_store("R4 r1 untouched", 0, 16'h0000, 16'h0011);
    endtask

    // R7 R8: stores and loads through ra + imm4 with wait states
    task automatic t_loadstore();
        clear_prog();
        dm[20] = 16'hBEEF;
        prog[0] = enc_i(2'd0, 4'd2, 8'h10);
        prog[1] = enc_m(2'd0, 4'd3, 4'd2, 4'd4);
        prog[2] = enc_m(2'd1, 4'd3, 4'd2, 4'd15);
        prog[3] = enc_m(2'd0, 4'd4, 4'd2, 4'd15);
        prog[4] = enc_m(2'd1, 4'd4, 4'd0, 4'd9);
        prog[5] = HALT;
        start(2);
        step(80);
        chk("R7 store count", 16'(st_cnt), 16'd2);
        chk_store("R7 R8 load then store", 0, 16'h001F, 16'hBEEF);
        chk_store("R8 reload", 1, 16'h0009, 16'hBEEF);
    endtask

    // R9: freeze while memory is not ready
    task automatic t_stall();
        clear_prog();
        prog[0] = enc_m(2'd1, 4'd0, 4'd0, 4'd0);
        prog[1] = HALT;
        start(3);
        step(1);
        chk("R9 no request in phase 2", {15'd0, dmem_valid}, 16'h0000);
        step(1);
        chk("R9 request in phase 3", {15'd0, dmem_valid}, 16'h0001);
        step(3);
        chk("R9 request held", {15'd0, dmem_valid}, 16'h0001);
        chk("R9 we held", {15'd0, dmem_we}, 16'h0001);
        step(1);
        chk("R9 request dropped", {15'd0, dmem_valid}, 16'h0000);
        chk("R9 addr before end", imem_addr, 16'h0000);
        step(1);
        chk("R9 addr after 4+3 cycles", imem_addr, 16'h0002);
    endtask

    // R10: forward branch and branch to itself
    task automatic t_branch();
        clear_prog();
        prog[0] = enc_i(2'd0, 4'd1, 8'h05);
        prog[1] = enc_i(2'd1, 4'd0, 8'h01);
        prog[2] = enc_i(2'd0, 4'd1, 8'h09);
        prog[3] = enc_m(2'd1, 4'd1, 4'd0, 4'd0);
        prog[4] = HALT;
        start(0);
        step(8);
        chk("R10 forward target", imem_addr, 16'h0006);
        step(60);
        chk("R10 self branch holds", imem_addr, 16'h0008);
        chk("R10 store count", 16'(st_cnt), 16'd1);
        chk_store("R10 skipped ldi", 0, 16'h0000, 16'h0005);
    endtask

    // R11: writes to r15 are dropped; r15 reads as own address
    task automatic t_pcreg();
        clear_prog();
        prog[0] = enc_i(2'd0, 4'd15, 8'h40);
        prog[1] = enc_m(2'd1, 4'd15, 4'd0, 4'd0);
        prog[2] = HALT;
        start(0);
        step(8);
        chk("R11 pc not overwritten", imem_addr, 16'h0004);
        step(30);
        chk("R11 store count", 16'(st_cnt), 16'd1);
        chk_store("R11 r15 operand", 0, 16'h0000, 16'h0002);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) dm[i] = '0;
        t_reset();
        t_timing();
        t_alu();
        t_nop();
        t_loadstore();
        t_stall();
        t_branch();
        t_pcreg();
        summary();
        $finish;
    end

endmodule